// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits between a synchronous user port and an external asynchronous static RAM of 256K words by 16 bits. A user issues one single-word transfer at a time: an 18-bit word address, a write flag, 16 bits of write data and a two-bit lane mask. The controller then drives the memory's active-low strobes (chip enable, write enable, output enable and one enable per byte lane), the address lines and the data bus. The data bus is split into an outgoing word, an incoming word and a drive-enable. Reads return the captured word together with a one-cycle done strobe. Writes strobe done once the cycle has fully ended.

Every memory timing limit is a nanosecond parameter, and the clock period is a parameter as well. Each limit is turned into a cycle count by rounding the ratio up, never below one cycle. Nothing is tuned by hand, so the same code covers other clock rates and other speed grades. New requests are taken only while the controller is idle.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is held, and right after it, every memory strobe is high, the bus drive-enable is low, `ready_o` is high and `done_o` is low.
- R2: A request is accepted only in a cycle where `ready_o` is high. A request pulse while busy is dropped: no further memory cycle follows, and the running transfer keeps its timing.
- R3: A read holds chip enable and output enable low, with write enable high, for ACC cycles, where ACC = ceil(T_ACCESS/period). The bus word is captured at the edge that ends those cycles, and `done_o` is sampled high ACC+1 sampling points after the request.
- R4: Lane bit 0 is the lower byte (bits 7:0) and lane bit 1 the upper byte (bits 15:8); a mask bit of 1 enables that lane. During a cycle, `mem_be_no` equals the inverted mask. On a read, the bits of a disabled lane return zero.
- R5: A write holds chip enable low with write enable high for SET cycles, then write enable low for PULSE cycles. PULSE = max(ceil(T_WP), ceil(T_DSET)). SET+PULSE covers the longest of the address, chip-select and lane to end-of-write minimums, and SET is at least 1. Write enable and chip enable rise on the same edge.
- R6: Write data is driven from the first cycle of the write until one cycle after the end-of-write edge. `done_o` follows in the cycle after that.
- R7: A lane whose mask bit is 0 keeps its old memory contents after a write.
- R8: While chip enable is low, the address and the lane enables do not change. The address changes only while write enable is high.
- R9: The bus is never driven while output enable is low. After output enable rises, the controller waits at least TURN = ceil(T_TURN/period) cycles before driving the bus, and `ready_o` comes back TURN cycles after the read's done strobe.
- R10: `done_o` is high for exactly one cycle per transfer.
- R11: All cycle counts follow ceil(ns / period) with a floor of 1. At the defaults (8 ns clock) this gives ACC=7, TURN=4, PULSE=4 and SET=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Transfer request, taken when ready_o is high |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 18 | Word address |
| wdata_i | input | 16 | Write data |
| lane_en_i | input | 2 | Byte lane mask, bit 0 lower byte |
| ready_o | output | 1 | Idle, able to take a request |
| done_o | output | 1 | One-cycle completion strobe |
| rdata_o | output | 16 | Captured read word |
| mem_addr_o | output | 18 | Memory address lines |
| mem_ce_no | output | 1 | Chip enable, active low |
| mem_we_no | output | 1 | Write enable, active low |
| mem_oe_no | output | 1 | Output enable, active low |
| mem_be_no | output | 2 | Byte enables, active low, bit 0 lower byte |
| mem_dq_o | output | 16 | Outgoing bus word |
| mem_dq_i | input | 16 | Incoming bus word |
| mem_dq_oe_o | output | 1 | Bus drive-enable |

## Verification
The assertions assume that the incoming bus word is only meaningful while the memory is selected and reading. They also assume that requests arrive only as synchronous pulses, with the write flag and fields steady in the cycle `ready_o` admits them. The stimulus drives every input at the falling clock edge. A request is held for exactly one sampling point, and a deliberate request during a busy write is kept to one cycle. The memory model in the bench returns a filler pattern whenever it is deselected, so any capture outside the read window shows up as a data mismatch.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ACC,
    ST_RD_GAP,
    ST_WR_SET,
    ST_WR_PULSE,
    ST_WR_END
  } state_e;

  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned period);
    int unsigned c;
    c = (ns + period - 1) / period;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned umax(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_cycle_timer.sv
module sram_cycle_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= load_val_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  // asserted in the last cycle of the loaded window
  assign last_o = (cnt_q == CNT_W'(1));
endmodule

// File: rtl/sram_lane_path.sv
module sram_lane_path #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned LANE_W = 8,
  localparam int unsigned DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_load_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             cap_i,
  input  logic [LANES-1:0] lane_en_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] out_q, cap_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        out_q <= '0;
        cap_q <= '0;
      end else begin
        if (wr_load_i) out_q <= wdata_i[g*LANE_W +: LANE_W];
        if (cap_i)     cap_q <= lane_en_i[g] ? dq_i[g*LANE_W +: LANE_W] : '0;
      end
    end

    assign dq_o[g*LANE_W +: LANE_W]    = out_q;
    assign rdata_o[g*LANE_W +: LANE_W] = cap_q;
  end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl #(
  parameter int unsigned ADDR_W        = 18,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned LANE_W        = 8,
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_ACCESS_NS   = 55,
  parameter int unsigned T_TURN_NS     = 25,
  parameter int unsigned T_ADDR_END_NS = 55,
  parameter int unsigned T_CS_END_NS   = 55,
  parameter int unsigned T_BE_END_NS   = 25,
  parameter int unsigned T_WP_NS       = 30,
  parameter int unsigned T_DSET_NS     = 25,
  localparam int unsigned LANES        = DATA_W / LANE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [LANES-1:0]  lane_en_i,
  output logic              ready_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic              mem_ce_no,
  output logic              mem_we_no,
  output logic              mem_oe_no,
  output logic [LANES-1:0]  mem_be_no,
  output logic [DATA_W-1:0] mem_dq_o,
  input  logic [DATA_W-1:0] mem_dq_i,
  output logic              mem_dq_oe_o
);
  import sram_ctrl_pkg::*;

  localparam int unsigned ACC_CYC   = ns_to_cyc(T_ACCESS_NS, CLK_PERIOD_NS);
  localparam int unsigned TURN_CYC  = ns_to_cyc(T_TURN_NS, CLK_PERIOD_NS);
  localparam int unsigned PULSE_CYC = umax(ns_to_cyc(T_WP_NS, CLK_PERIOD_NS),
                                           ns_to_cyc(T_DSET_NS, CLK_PERIOD_NS));
  localparam int unsigned TOT_CYC   = umax(umax(ns_to_cyc(T_ADDR_END_NS, CLK_PERIOD_NS),
                                                ns_to_cyc(T_CS_END_NS, CLK_PERIOD_NS)),
                                           ns_to_cyc(T_BE_END_NS, CLK_PERIOD_NS));
  localparam int unsigned SET_CYC   = (TOT_CYC > PULSE_CYC) ? TOT_CYC - PULSE_CYC : 1;
  localparam int unsigned MAX_CYC   = umax(umax(ACC_CYC, TURN_CYC), umax(PULSE_CYC, SET_CYC));
  localparam int unsigned CNT_W     = $clog2(MAX_CYC + 1);

  state_e             state_q;
  logic [LANES-1:0]   lane_q;
  logic               tmr_load, tmr_last, accept, cap;
  logic [CNT_W-1:0]   tmr_val;

  assign accept  = req_i && (state_q == ST_IDLE);
  assign cap     = (state_q == ST_RD_ACC) && tmr_last;
  assign ready_o = (state_q == ST_IDLE);

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: if (req_i) begin
        tmr_load = 1'b1;
        tmr_val  = wr_i ? CNT_W'(SET_CYC) : CNT_W'(ACC_CYC);
      end
      ST_RD_ACC: if (tmr_last) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(TURN_CYC);
      end
      ST_WR_SET: if (tmr_last) begin
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(PULSE_CYC);
      end
      default: ;
    endcase
  end

  sram_cycle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  sram_lane_path #(.LANES(LANES), .LANE_W(LANE_W)) u_lanes (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_load_i (accept && wr_i),
    .wdata_i   (wdata_i),
    .cap_i     (cap),
    .lane_en_i (lane_q),
    .dq_i      (mem_dq_i),
    .dq_o      (mem_dq_o),
    .rdata_o   (rdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      lane_q      <= '0;
      mem_addr_o  <= '0;
      mem_ce_no   <= 1'b1;
      mem_we_no   <= 1'b1;
      mem_oe_no   <= 1'b1;
      mem_be_no   <= '1;
      mem_dq_oe_o <= 1'b0;
      done_o      <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (req_i) begin
          // address moves only here, with write enable high
          mem_addr_o <= addr_i;
          lane_q     <= lane_en_i;
          mem_ce_no  <= 1'b0;
          mem_be_no  <= ~lane_en_i;
          if (wr_i) begin
            mem_dq_oe_o <= 1'b1;
            state_q     <= ST_WR_SET;
          end else begin
            mem_oe_no <= 1'b0;
            state_q   <= ST_RD_ACC;
          end
        end
        ST_RD_ACC: if (tmr_last) begin
          mem_ce_no <= 1'b1;
          mem_oe_no <= 1'b1;
          mem_be_no <= '1;
          done_o    <= 1'b1;
          state_q   <= ST_RD_GAP;
        end
        ST_RD_GAP: if (tmr_last) state_q <= ST_IDLE;
        ST_WR_SET: if (tmr_last) begin
          mem_we_no <= 1'b0;
          state_q   <= ST_WR_PULSE;
        end
        ST_WR_PULSE: if (tmr_last) begin
          mem_we_no <= 1'b1;
          mem_ce_no <= 1'b1;
          mem_be_no <= '1;
          state_q   <= ST_WR_END;
        end
        ST_WR_END: begin
          mem_dq_oe_o <= 1'b0;
          done_o      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctrl_checker.sv
module sram_ctrl_checker #(
  parameter int unsigned ADDR_W    = 18,
  parameter int unsigned LANES     = 2,
  parameter int unsigned TURN_CYC  = 4,
  parameter int unsigned PULSE_CYC = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              ready_o,
  input logic              done_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic              mem_ce_no,
  input logic              mem_we_no,
  input logic              mem_oe_no,
  input logic [LANES-1:0]  mem_be_no,
  input logic              mem_dq_oe_o
);
  logic [7:0] we_low_cnt, oe_hi_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_low_cnt <= '0;
      oe_hi_cnt  <= '1;
    end else begin
      we_low_cnt <= mem_we_no ? '0 : we_low_cnt + 1'b1;
      if (!mem_oe_no)            oe_hi_cnt <= '0;
      else if (oe_hi_cnt != '1)  oe_hi_cnt <= oe_hi_cnt + 1'b1;
    end
  end

  p_accept_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ready_o) |=> (!mem_ce_no && !ready_o));

  p_we_in_select_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mem_we_no |-> (!mem_ce_no && mem_oe_no));

  p_we_width_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_we_no) |-> (we_low_cnt == 8'(PULSE_CYC)));

  p_addr_we_high_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(mem_addr_o) |-> (mem_we_no && $past(mem_we_no)));

  p_select_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mem_ce_no && $past(!mem_ce_no)) |-> ($stable(mem_addr_o) && $stable(mem_be_no)));

  p_no_clash_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_dq_oe_o |-> mem_oe_no);

  p_turnaround_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_dq_oe_o) |-> (oe_hi_cnt >= 8'(TURN_CYC)));

  p_done_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind sram_ctrl sram_ctrl_checker #(
  .ADDR_W(ADDR_W), .LANES(LANES), .TURN_CYC(TURN_CYC), .PULSE_CYC(PULSE_CYC)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .ready_o(ready_o), .done_o(done_o),
  .mem_addr_o(mem_addr_o), .mem_ce_no(mem_ce_no), .mem_we_no(mem_we_no),
  .mem_oe_no(mem_oe_no), .mem_be_no(mem_be_no), .mem_dq_oe_o(mem_dq_oe_o)
);

// File: tb/sram_ctrl_test.sv
module sram_ctrl_test;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [17:0] addr = '0;
  logic [15:0] wdata = '0;
  logic [1:0]  lane = '0;
  logic        ready, done, ce_n, we_n, oe_n, dq_oe;
  logic [15:0] rdata, dq_o;
  logic [15:0] dq_i = 16'hA5C3;
  logic [17:0] mem_addr;
  logic [1:0]  be_n;

  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  sram_ctrl uut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .lane_en_i(lane), .ready_o(ready), .done_o(done),
    .rdata_o(rdata), .mem_addr_o(mem_addr), .mem_ce_no(ce_n), .mem_we_no(we_n),
    .mem_oe_no(oe_n), .mem_be_no(be_n), .mem_dq_o(dq_o), .mem_dq_i(dq_i),
    .mem_dq_oe_o(dq_oe)
  );

  function automatic int cyc(input int ns);
    int c = (ns + 7) / 8;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int E_ACC   = (55 + 7) / 8;
  localparam int E_TURN  = (25 + 7) / 8;
  int e_pulse, e_set;

  function automatic logic [15:0] init_word(input logic [17:0] a);
    return a[15:0] ^ {a[17:16], 14'h1A5A};
  endfunction

  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];

  function automatic logic [15:0] dev_rd(input logic [17:0] a);
    return dev_mem.exists(int'(a)) ? dev_mem[int'(a)] : init_word(a);
  endfunction
  function automatic logic [15:0] ref_rd(input logic [17:0] a);
    return ref_mem.exists(int'(a)) ? ref_mem[int'(a)] : init_word(a);
  endfunction
  function automatic logic [15:0] lane_mask(input logic [1:0] m);
    return {{8{m[1]}}, {8{m[0]}}};
  endfunction

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", r, act, exp, $time);
    end
  endtask

  // device model: write commits when the select/write overlap ends
  logic        w_act = 1'b0;
  logic [17:0] w_addr;
  logic [15:0] w_data;
  logic [1:0]  w_be_n;
  int          oe_gap = 100;
  logic        dq_oe_prev = 1'b0;

  always @(negedge clk) begin
    if (!ce_n && !we_n) begin
      w_act  <= 1'b1;
      w_addr <= mem_addr;
      w_data <= dq_o;
      w_be_n <= be_n;
    end else if (w_act) begin
      logic [15:0] old;
      old = dev_rd(w_addr);
      dev_mem[int'(w_addr)] = (old & lane_mask(w_be_n)) | (w_data & ~lane_mask(w_be_n));
      w_act <= 1'b0;
    end
    dq_i <= (!ce_n && !oe_n && we_n) ? dev_rd(mem_addr) : 16'hA5C3;
    if (rst_n) begin
      if (dq_oe && !oe_n) chk(1'b0, "R9 clash", 32'(dq_oe), 0);
      if (dq_oe && !dq_oe_prev) chk(oe_gap >= E_TURN, "R9 turnaround", oe_gap, E_TURN);
    end
    oe_gap     = oe_n ? oe_gap + 1 : 0;
    dq_oe_prev = dq_oe;
  end

  task automatic do_op(input bit w, input logic [17:0] a, input logic [15:0] d,
                       input logic [1:0] m, input bit poke);
    int k, set_cnt, pul_cnt;
    bit seen_we;
    logic [15:0] exp;
    set_cnt = 0; pul_cnt = 0; seen_we = 0; k = 0;
    while (!ready) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d; lane = m;
    exp = ref_rd(a) & lane_mask(m);
    if (w) ref_mem[int'(a)] = (ref_rd(a) & ~lane_mask(m)) | (d & lane_mask(m));
    for (int i = 1; i < 64; i++) begin
      @(negedge clk);
      k = i;
      req = (poke && i == 3);
      if (poke && i == 3) begin wr = 1'b0; addr = a ^ 18'h155; end
      if (!ce_n) begin
        chk(mem_addr == a && be_n == ~m, "R8/R4 addr+lanes", {mem_addr, be_n}, {a, ~m});
        if (w) begin
          if (we_n && !seen_we) set_cnt++;
          if (!we_n) begin pul_cnt++; seen_we = 1; end
          chk(dq_oe && dq_o == d, "R6 write data", dq_o, d);
        end else
          chk(!oe_n && we_n, "R3 read strobes", {oe_n, we_n}, 2'b01);
      end
      if (w && i == e_set + e_pulse + 1)
        chk(dq_oe && ce_n && we_n, "R6 hold past end", {dq_oe, ce_n, we_n}, 3'b111);
      if (done) break;
    end
    if (w) begin
      chk(k == e_set + e_pulse + 2, "R6/R11 write done latency", k, e_set + e_pulse + 2);
      chk(set_cnt == e_set, "R5/R11 setup cycles", set_cnt, e_set);
      chk(pul_cnt == e_pulse, "R5/R11 pulse cycles", pul_cnt, e_pulse);
      chk(!dq_oe, "R6 bus released", dq_oe, 0);
    end else begin
      chk(k == E_ACC + 1, "R3/R11 read latency", k, E_ACC + 1);
      chk(rdata == exp, "R3/R4 read data", rdata, exp);
    end
    @(negedge clk);
    chk(!done, "R10 done one cycle", done, 0);
    if (!w) begin
      int t = 1;
      while (!ready && t < 64) begin @(negedge clk); t++; end
      chk(t == E_TURN, "R9 ready after turnaround", t, E_TURN);
    end
    if (poke) begin
      for (int j = 0; j < 3; j++) begin
        @(negedge clk);
        chk(ce_n && ready, "R2 busy request dropped", {ce_n, ready}, 2'b11);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    e_pulse = (cyc(30) > cyc(25)) ? cyc(30) : cyc(25);
    e_set   = (cyc(55) > e_pulse) ? cyc(55) - e_pulse : 1;
    repeat (3) @(negedge clk);
    chk(ce_n && we_n && oe_n && be_n == 2'b11 && !dq_oe && ready && !done,
        "R1 reset state", {ce_n, we_n, oe_n, be_n, dq_oe, ready, done}, 8'b11111010);
    rst_n = 1'b1;
    @(negedge clk);
    chk(ce_n && ready && !done, "R1 after reset", {ce_n, ready, done}, 3'b110);

    // directed corners
    do_op(1'b0, 18'h3FFFF, 16'h0, 2'b11, 1'b0);
    do_op(1'b1, 18'h3FFFF, 16'hBEEF, 2'b11, 1'b0);
    do_op(1'b0, 18'h3FFFF, 16'h0, 2'b11, 1'b0);
    do_op(1'b1, 18'h00010, 16'h1234, 2'b01, 1'b0);   // R7 upper lane untouched
    do_op(1'b0, 18'h00010, 16'h0, 2'b11, 1'b0);
    do_op(1'b1, 18'h00010, 16'hABCD, 2'b10, 1'b0);   // R7 lower lane untouched
    do_op(1'b0, 18'h00010, 16'h0, 2'b11, 1'b0);
    do_op(1'b1, 18'h00011, 16'hFFFF, 2'b00, 1'b0);   // R7 nothing written
    do_op(1'b0, 18'h00011, 16'h0, 2'b11, 1'b0);
    do_op(1'b0, 18'h00010, 16'h0, 2'b01, 1'b0);      // R4 upper bits read as zero
    do_op(1'b1, 18'h00020, 16'h5555, 2'b11, 1'b1);   // R2 request during busy
    do_op(1'b0, 18'h00020, 16'h0, 2'b11, 1'b0);

    // random mix
    for (int i = 0; i < 200; i++) begin
      logic [17:0] a;
      a = 18'($urandom % 24);
      do_op(1'($urandom), a, 16'($urandom), 2'($urandom), 1'b0);
    end
    for (int i = 0; i < 24; i++) do_op(1'b0, 18'(i), 16'h0, 2'b11, 1'b0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule